// File: doc/BRIEF.md
# UART Line Status Generator

This block builds the 32-bit line status word of a UART receiver/transmitter pair. It also raises the two status-driven interrupt requests. Received characters arrive on a valid/ready stream, each carrying its data byte and four condition flags: parity, framing, break and overrun. They are held in a small receive queue. In queued mode the queue is sixteen entries deep. In single-buffer mode it holds one character. Every entry keeps its own error flags, and a running count of errored entries drives the receive-error summary bit. That bit therefore stays up until the last bad character has been read out.

The transmit side does not store data. It takes three inputs: the emptiness of the external holding register or transmit queue, the busy signal of the transmit shifter, and the CPU's transmit-write strobe. From these it derives the holding-empty and transmitter-empty bits.

The receive stream has one back-pressure rule. `rx_ready` is high while the queue holds fewer characters than its current capacity. A serial receiver cannot wait. A character offered while `rx_ready` is low is therefore discarded, and it sets the overrun bit instead of stalling the source. All results are registered state, and the status word is decoded from that state without further delay.

Top module: `uart_line_status`

## Requirements
- R1: After reset the status word reads 0x0000_0060, so only bit 5 (holding empty) and bit 6 (transmitter empty) are set. Both interrupt requests are low and `rx_ready` is high.
- R2: Bits 31..8 always read 0. Bit 0 (data ready) is 1 whenever the receive queue holds at least one character.
- R3: The capacity is 16 characters when queued mode is active and 1 otherwise. `rx_ready` is high below capacity. A character is taken when `rx_valid && rx_ready`. A data-read strobe removes the head, and characters leave in arrival order, with the head visible on `rx_head_data`.
- R4: Bit 1 (overrun) is set by a character offered while `rx_ready` is low, or by one accepted with `rx_overrun` set. It clears on a status-read strobe.
- R5: Bits 2, 3 and 4 (parity, framing, break) show the flags of the head character. A status-read strobe hides them until a different character becomes the head.
- R6: In queued mode, bit 7 (receive error) is 1 while any stored character has a parity, framing or break flag. It falls only when the last such character is removed. A status read does not clear it. A simultaneous push and pop updates the count of errored entries correctly.
- R7: In single-buffer mode, bit 7 follows the one buffered character and clears when that character is read.
- R8: A change of `fifo_mode_en` empties the queue within one cycle, clearing bits 0 and 7.
- R9: Bit 5 is 0 in the cycle after a `cpu_tx_wr` strobe. It returns to 1 once `tx_pend_empty` is high with no write.
- R10: Bit 6 is 1 only when bit 5 is 1 and the transmit shifter was idle.
- R11: `irq_tx` is high exactly while bit 5 and `tx_irq_en` are both 1.
- R12: `irq_rx_line` is high exactly while any of bits 1 to 4 is set.
- R13: A write strobe to the status address, with any data, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_mode_en | input | 1 | 1 selects the 16-entry queue, 0 the single buffer |
| rx_valid | input | 1 | A received character is offered |
| rx_ready | output | 1 | Space in the queue |
| rx_data | input | 8 | Received character |
| rx_parity_err | input | 1 | Character had a parity error |
| rx_frame_err | input | 1 | Character had a framing error |
| rx_break | input | 1 | Break condition seen |
| rx_overrun | input | 1 | Receiver lost a character before this one |
| rd_data_strobe | input | 1 | CPU read of the receive data register |
| rx_head_data | output | 8 | Character at the head of the queue |
| rd_status_strobe | input | 1 | CPU read of the status word |
| status_wr | input | 1 | CPU write to the status address (ignored) |
| status_wr_data | input | 32 | Data of that write (ignored) |
| cpu_tx_wr | input | 1 | CPU wrote a transmit character |
| tx_pend_empty | input | 1 | Holding register or transmit queue is empty |
| tx_shift_busy | input | 1 | Transmit shifter is sending |
| tx_irq_en | input | 1 | Transmit-empty interrupt enable |
| status_word | output | 32 | Line status word |
| irq_rx_line | output | 1 | Receiver line status interrupt request |
| irq_tx | output | 1 | Transmit holding empty interrupt request |

## Verification
Any input or strobe sampled at a rising edge changes the status word, `rx_ready`, `rx_head_data` and `irq_rx_line` right after that edge, one register deep. `irq_tx` follows `tx_irq_en` with no register at all. The bench drives every input on the falling edge and samples one falling edge later, which is half a period after the edge that must have taken effect. Pre-pop checks of `rx_head_data` are made before the strobe is applied. This keeps every expectation exactly one register stage away from its cause.

// File: rtl/uart_ls_pkg.sv
package uart_ls_pkg;
  typedef struct packed {
    logic brk;
    logic frame;
    logic parity;
  } rx_err_t;

  localparam int unsigned STATUS_W  = 32;
  localparam int unsigned BIT_READY = 0;
  localparam int unsigned BIT_OVR   = 1;
  localparam int unsigned BIT_PAR   = 2;
  localparam int unsigned BIT_FRM   = 3;
  localparam int unsigned BIT_BRK   = 4;
  localparam int unsigned BIT_HOLD  = 5;
  localparam int unsigned BIT_EMPTY = 6;
  localparam int unsigned BIT_RXERR = 7;
endpackage

// File: rtl/uart_ls_rx_fifo.sv
module uart_ls_rx_fifo
  import uart_ls_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wide_mode,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  rx_err_t           push_err,
  input  logic              pop,
  output logic [DATA_W-1:0] head_data,
  output rx_err_t           head_err,
  output logic [CNT_W-1:0]  count,
  output logic              has_room
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem_data [DEPTH];
  rx_err_t           mem_err  [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  limit;

  assign limit     = wide_mode ? CNT_W'(DEPTH) : CNT_W'(1);
  assign has_room  = !flush && (count < limit);
  assign head_data = mem_data[rd_ptr];
  assign head_err  = mem_err[rd_ptr];

  always_ff @(posedge clk) begin
    if (push && !flush) begin
      mem_data[wr_ptr] <= push_data;
      mem_err[wr_ptr]  <= push_err;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R3: occupancy never exceeds the capacity of the active mode
  assert_count_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= limit);
  // R3: a removal is only ever requested on a non-empty queue
  assert_pop_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> count != '0);
endmodule

// File: rtl/uart_ls_err_count.sv
module uart_ls_err_count #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic             push_bad,
  input  logic             pop,
  input  logic             pop_bad,
  output logic [CNT_W-1:0] bad_cnt,
  output logic             any_bad
);
  logic inc, dec;

  assign inc     = push && push_bad;
  assign dec     = pop && pop_bad;
  assign any_bad = bad_cnt != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         bad_cnt <= '0;
    else if (flush)     bad_cnt <= '0;
    else if (inc && !dec) bad_cnt <= bad_cnt + 1'b1;
    else if (dec && !inc) bad_cnt <= bad_cnt - 1'b1;
  end

  // R6: removing an errored entry never finds the count already at zero
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> bad_cnt != '0);
  // R6: push and pop of errored entries together leave the count unchanged
  assert_balanced_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && dec && !flush) |=> $stable(bad_cnt));
endmodule

// File: rtl/uart_ls_tx_status.sv
module uart_ls_tx_status (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_tx_wr,
  input  logic pend_empty,
  input  logic shift_busy,
  input  logic irq_en,
  output logic hold_empty,
  output logic all_empty,
  output logic irq_tx
);
  logic hold_next;

  always_comb begin
    hold_next = hold_empty;
    if (cpu_tx_wr)       hold_next = 1'b0;
    else if (pend_empty) hold_next = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_empty <= 1'b1;
      all_empty  <= 1'b1;
    end else begin
      hold_empty <= hold_next;
      all_empty  <= hold_next && !shift_busy;
    end
  end

  assign irq_tx = hold_empty && irq_en;

  // R9: a CPU write always leaves the holding bit low in the next cycle
  assert_hold_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_tx_wr |=> !hold_empty);
  // R10: transmitter empty never appears without holding empty
  assert_empty_needs_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    all_empty |-> hold_empty);
  // R10: a busy shifter forces transmitter empty low next cycle
  assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    shift_busy |=> !all_empty);
endmodule

// File: rtl/uart_line_status.sv
module uart_line_status
  import uart_ls_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_mode_en,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_parity_err,
  input  logic              rx_frame_err,
  input  logic              rx_break,
  input  logic              rx_overrun,
  input  logic              rd_data_strobe,
  output logic [DATA_W-1:0] rx_head_data,
  input  logic              rd_status_strobe,
  input  logic              status_wr,
  input  logic [31:0]       status_wr_data,
  input  logic              cpu_tx_wr,
  input  logic              tx_pend_empty,
  input  logic              tx_shift_busy,
  input  logic              tx_irq_en,
  output logic [31:0]       status_word,
  output logic              irq_rx_line,
  output logic              irq_tx
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic             mode_q, flush;
  logic             push, pop;
  rx_err_t          in_err, head_err;
  logic [CNT_W-1:0] count, bad_cnt;
  logic             any_bad, has_data;
  logic             ovr_q, head_seen_q;
  logic             hold_empty, all_empty;
  logic             show_head;
  logic             unused_wr;

  // Writes to the status address are accepted and dropped.
  assign unused_wr = ^{status_wr, status_wr_data};

  assign flush    = fifo_mode_en != mode_q;
  assign in_err   = '{brk: rx_break, frame: rx_frame_err, parity: rx_parity_err};
  assign push     = rx_valid && rx_ready;
  assign has_data = count != '0;
  assign pop      = rd_data_strobe && has_data && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= fifo_mode_en;
  end

  uart_ls_rx_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .wide_mode (mode_q),
    .push      (push),
    .push_data (rx_data),
    .push_err  (in_err),
    .pop       (pop),
    .head_data (rx_head_data),
    .head_err  (head_err),
    .count     (count),
    .has_room  (rx_ready)
  );

  uart_ls_err_count #(.CNT_W(CNT_W)) u_errcnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .push     (push),
    .push_bad (|in_err),
    .pop      (pop),
    .pop_bad  (|head_err),
    .bad_cnt  (bad_cnt),
    .any_bad  (any_bad)
  );

  uart_ls_tx_status u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_tx_wr  (cpu_tx_wr),
    .pend_empty (tx_pend_empty),
    .shift_busy (tx_shift_busy),
    .irq_en     (tx_irq_en),
    .hold_empty (hold_empty),
    .all_empty  (all_empty),
    .irq_tx     (irq_tx)
  );

  // Sticky overrun: a new event wins over a clearing status read.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ovr_q <= 1'b0;
    else if (rx_valid && (!rx_ready || rx_overrun))
      ovr_q <= 1'b1;
    else if (rd_status_strobe)
      ovr_q <= 1'b0;
  end

  // Marks the head's flags as already reported by a status read.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      head_seen_q <= 1'b0;
    else if (flush || pop)
      head_seen_q <= 1'b0;
    else if (rd_status_strobe && has_data)
      head_seen_q <= 1'b1;
  end

  assign show_head = has_data && !head_seen_q;

  always_comb begin
    status_word            = '0;
    status_word[BIT_READY] = has_data;
    status_word[BIT_OVR]   = ovr_q;
    status_word[BIT_PAR]   = show_head && head_err.parity;
    status_word[BIT_FRM]   = show_head && head_err.frame;
    status_word[BIT_BRK]   = show_head && head_err.brk;
    status_word[BIT_HOLD]  = hold_empty;
    status_word[BIT_EMPTY] = all_empty;
    status_word[BIT_RXERR] = any_bad;
  end

  assign irq_rx_line = |status_word[BIT_BRK:BIT_OVR];

  // R4: a character offered without room sets overrun in the next cycle
  assert_overrun_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> status_word[BIT_OVR]);
  // R6: errored entries can never outnumber stored entries
  assert_bad_le_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cnt <= count);
  // R8: a mode change leaves the queue empty in the next cycle
  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0) && !any_bad);
  // R12: the line interrupt requires an overrun or a stored character
  assert_irq_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx_line |-> (ovr_q || has_data));
endmodule

// File: tb/uart_line_status_bench.sv
module uart_line_status_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fifo_mode_en = 1'b0;
  logic        rx_valid = 1'b0, rx_ready;
  logic [7:0]  rx_data = '0;
  logic        rx_parity_err = 1'b0, rx_frame_err = 1'b0, rx_break = 1'b0, rx_overrun = 1'b0;
  logic        rd_data_strobe = 1'b0, rd_status_strobe = 1'b0;
  logic [7:0]  rx_head_data;
  logic        status_wr = 1'b0;
  logic [31:0] status_wr_data = '0;
  logic        cpu_tx_wr = 1'b0, tx_pend_empty = 1'b1, tx_shift_busy = 1'b0, tx_irq_en = 1'b0;
  logic [31:0] status_word;
  logic        irq_rx_line, irq_tx;

  int n_checks = 0;
  int n_errors = 0;

  always #2 clk = ~clk;

  uart_line_status u_uart_line_status (.*);

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push_char(logic [7:0] d, logic p, logic f, logic b);
    rx_valid = 1'b1; rx_data = d;
    rx_parity_err = p; rx_frame_err = f; rx_break = b;
    step();
    rx_valid = 1'b0; rx_parity_err = 1'b0; rx_frame_err = 1'b0; rx_break = 1'b0;
  endtask

  task automatic read_status();
    rd_status_strobe = 1'b1; step(); rd_status_strobe = 1'b0;
  endtask

  task automatic read_data();
    rd_data_strobe = 1'b1; step(); rd_data_strobe = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "status", status_word, 32'h60);
    chk("R1", "irq_rx_line", {31'b0, irq_rx_line}, 0);
    chk("R1", "irq_tx", {31'b0, irq_tx}, 0);
    chk("R1", "rx_ready", {31'b0, rx_ready}, 1);
  endtask

  task automatic t_single_clean();
    push_char(8'h41, 0, 0, 0);
    chk("R2", "status one char", status_word, 32'h61);
    chk("R3", "ready at capacity 1", {31'b0, rx_ready}, 0);
    chk("R3", "head", {24'b0, rx_head_data}, 32'h41);
    push_char(8'h42, 0, 0, 0);
    chk("R4", "overrun on full", status_word, 32'h63);
    chk("R12", "irq on overrun", {31'b0, irq_rx_line}, 1);
    read_status();
    chk("R4", "overrun cleared", status_word, 32'h61);
    chk("R12", "irq dropped", {31'b0, irq_rx_line}, 0);
    chk("R3", "head kept first", {24'b0, rx_head_data}, 32'h41);
    read_data();
    chk("R2", "empty after read", status_word, 32'h60);
  endtask

  task automatic t_single_err();
    push_char(8'h55, 1, 0, 0);
    chk("R5", "parity shown", status_word, 32'hE5);
    chk("R12", "irq parity", {31'b0, irq_rx_line}, 1);
    read_status();
    chk("R5", "parity hidden after status read", status_word, 32'hE1);
    read_data();
    chk("R7", "single error cleared by data read", status_word, 32'h60);
    rx_overrun = 1'b1;
    push_char(8'h56, 0, 0, 0);
    rx_overrun = 1'b0;
    chk("R4", "overrun flag with char", status_word, 32'h63);
    read_status();
    read_data();
  endtask

  task automatic t_write_ignored();
    push_char(8'h22, 0, 1, 0);
    chk("R5", "framing shown", status_word, 32'hE9);
    status_wr = 1'b1; status_wr_data = 32'hFFFF_FFFF; step();
    status_wr_data = 32'h0; step();
    status_wr = 1'b0;
    chk("R13", "write ignored", status_word, 32'hE9);
    chk("R13", "head intact", {24'b0, rx_head_data}, 32'h22);
    read_data();
    chk("R7", "cleared", status_word, 32'h60);
  endtask

  task automatic t_fifo_fill();
    fifo_mode_en = 1'b1; step();
    chk("R8", "switch leaves empty", status_word, 32'h60);
    for (int i = 0; i < 16; i++)
      push_char(8'h10 + 8'(i), (i == 10), 1'b0, (i == 3));
    chk("R3", "ready low at 16", {31'b0, rx_ready}, 0);
    chk("R6", "error summary", status_word, 32'hE1);
    push_char(8'h99, 0, 0, 0);
    chk("R4", "17th dropped", status_word, 32'hE3);
    read_status();
    for (int i = 0; i < 16; i++) begin
      chk("R3", "order", {24'b0, rx_head_data}, 32'h10 + i);
      if (i == 3)  chk("R5", "break at head", {31'b0, status_word[4]}, 1);
      if (i == 10) chk("R5", "parity at head", {31'b0, status_word[2]}, 1);
      read_data();
      chk("R6", "summary while errors remain", {31'b0, status_word[7]}, (i < 10) ? 1 : 0);
    end
    chk("R2", "drained", status_word, 32'h60);
  endtask

  task automatic t_fifo_simul();
    push_char(8'h70, 1, 0, 0);
    rd_data_strobe = 1'b1;
    push_char(8'h71, 1, 0, 0);
    rd_data_strobe = 1'b0;
    chk("R6", "errored push+pop keeps summary", {24'b0, status_word[7:0]}, 32'hE5);
    chk("R6", "new head", {24'b0, rx_head_data}, 32'h71);
    rd_data_strobe = 1'b1;
    push_char(8'h72, 0, 0, 0);
    rd_data_strobe = 1'b0;
    chk("R6", "clean push+errored pop clears", status_word, 32'h61);
    read_data();
    chk("R2", "empty", status_word, 32'h60);
  endtask

  task automatic t_flush();
    push_char(8'h80, 0, 1, 0);
    push_char(8'h81, 0, 0, 0);
    fifo_mode_en = 1'b0; step();
    chk("R8", "mode change flushes", status_word, 32'h60);
    chk("R8", "ready after flush", {31'b0, rx_ready}, 1);
  endtask

  task automatic t_tx();
    tx_pend_empty = 1'b0; cpu_tx_wr = 1'b1; step(); cpu_tx_wr = 1'b0;
    chk("R9", "holding low after write", {30'b0, status_word[6:5]}, 0);
    step();
    chk("R9", "holding stays low", {30'b0, status_word[6:5]}, 0);
    tx_pend_empty = 1'b1; tx_shift_busy = 1'b1; step();
    chk("R10", "holding set, shifter busy", {30'b0, status_word[6:5]}, 1);
    chk("R11", "irq_tx disabled", {31'b0, irq_tx}, 0);
    tx_irq_en = 1'b1; step();
    chk("R11", "irq_tx enabled", {31'b0, irq_tx}, 1);
    tx_shift_busy = 1'b0; step();
    chk("R10", "all empty", {30'b0, status_word[6:5]}, 3);
    cpu_tx_wr = 1'b1; tx_pend_empty = 1'b0; step(); cpu_tx_wr = 1'b0;
    chk("R11", "irq_tx drops on write", {31'b0, irq_tx}, 0);
    chk("R9", "status after write", status_word, 32'h00);
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_clean();
    t_single_err();
    t_write_ignored();
    t_fifo_fill();
    t_fifo_simul();
    t_flush();
    t_tx();
    finish_sim();
  end
endmodule